// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines into one interrupt signal for a processor. It is built from two identical eight-line priority units. The lower unit (lines 8 to 15) feeds its single output into input 2 of the upper unit (lines 0 to 7), so the whole group of lower-unit lines competes at the priority position of line 2. Each line can be disabled through a per-unit mask register. Among the enabled requests that are not held back by an interrupt already being serviced, the unit picks the most urgent one and raises `cpu_int`.

When the processor acknowledges with a one-cycle `cpu_ack` pulse, the block returns an 8-bit vector rather than the line number. It also marks that line as in service, which holds off requests of the same or lower priority until software writes an end-of-interrupt command. Software reaches the registers through a simple byte-wide read/write port at four fixed addresses. A read of a control register returns the number of the line currently in service.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset both mask registers read FFh (all lines disabled), both control registers read FFh (nothing in service) and `cpu_int` is low.
- R2: A mask bit of 1 disables its line and 0 enables it. Bit n at address 21h controls line n. Bit n at address A1h controls line 8+n. Master bit 2 disables all of lines 8 to 15 at once.
- R3: Priority is fixed. Line 0 is the most urgent and line 15 the least. Lines 8 to 15 as a group rank between line 1 and line 3, and within that group line 8 ranks first.
- R4: The vector for line n (0 to 7) is 08h+n and the vector for line 8+k is 70h+k. `ack_vector` holds it from the clock edge that samples `cpu_ack` until the next acknowledge.
- R5: An acknowledged line is in service and blocks itself and all lower-priority lines of its unit. A register write with data bit 5 set is an end-of-interrupt command: at address 20h it goes to the master, at A0h to the slave. It clears that unit's highest-priority in-service bit.
- R6: A read of address 20h returns the master's highest-priority in-service line (0 to 7), or FFh if none. A read of A0h returns the slave's highest-priority in-service line as 8 to 15, or FFh if none. `reg_rdata` is valid in the cycle after `reg_rd`.
- R7: Acknowledging a slave line sets in-service state in both units: the slave line itself and master line 2. Lines below line 2 in priority stay blocked until end-of-interrupt has been written to both units.
- R8: A request of higher priority than every in-service line raises `cpu_int` and can be acknowledged while the lower one is still in service.
- R9: An acknowledge with no eligible request returns vector 0Fh and changes no in-service state.
- R10: Requests pass through a two-stage synchroniser. `cpu_int` is registered and rises at the third rising clock edge after a newly enabled request is first high. A request withdrawn before acknowledge lets `cpu_int` fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Level-sensitive request lines; bit n is line n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address (20h, 21h, A0h, A1h) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| cpu_int | output | 1 | Registered interrupt request to the processor |
| ack_vector | output | 8 | Vector returned for the last acknowledge |

## Verification
Every cycle, the assertions check four things. The reset state holds. No line enters service without an acknowledge, and no line enters service while it is masked. A slave line never enters service unless master line 2 does too. Every returned vector falls inside one of the two vector windows. Several behaviours need a sequence of stimulus and can only be shown by the bench scenarios: the exact priority winner between competing lines, nesting and preemption across several end-of-interrupt commands, the need for end-of-interrupt on both units, and the three-edge request latency.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int unsigned CTRL_LINES   = 8;
  localparam int unsigned CASC_INPUT   = 2;
  localparam int unsigned EOI_BIT      = 5;
  localparam logic [7:0]  M_CTRL_ADDR  = 8'h20;
  localparam logic [7:0]  M_MASK_ADDR  = 8'h21;
  localparam logic [7:0]  S_CTRL_ADDR  = 8'hA0;
  localparam logic [7:0]  S_MASK_ADDR  = 8'hA1;
  localparam logic [7:0]  M_VEC_BASE   = 8'h08;
  localparam logic [7:0]  S_VEC_BASE   = 8'h70;
  localparam logic [7:0]  NONE_CODE    = 8'hFF;

  // Byte reported for a serviced line: offset plus local index, or the idle code.
  function automatic logic [7:0] svc_code(input logic any, input logic [7:0] idx,
                                          input logic [7:0] ofs);
    return any ? (ofs + idx) : NONE_CODE;
  endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pirq_unit.sv
module pirq_unit #(
  parameter  int unsigned LINES = 8,
  localparam int unsigned IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_wd,
  input  logic             eoi,
  input  logic             take,
  output logic             irq_out,
  output logic [IW-1:0]    pick,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] isr_q,
  output logic             svc_any,
  output logic [IW-1:0]    svc_idx
);
  logic [LINES-1:0] pend, allow, elig, isr_nxt;
  logic             blocked;

  // Lines strictly above the most urgent in-service line may still request.
  always_comb begin
    pend    = req & ~mask_q;
    blocked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      blocked  = blocked | isr_q[i];
      allow[i] = ~blocked;
    end
    elig = pend & allow;
  end

  // Lowest index wins in both searches: scan downward, last hit kept.
  always_comb begin
    irq_out = 1'b0;
    pick    = '0;
    svc_any = 1'b0;
    svc_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        irq_out = 1'b1;
        pick    = IW'(i);
      end
      if (isr_q[i]) begin
        svc_any = 1'b1;
        svc_idx = IW'(i);
      end
    end
  end

  always_comb begin
    isr_nxt = isr_q;
    if (eoi && svc_any) isr_nxt[svc_idx] = 1'b0;
    if (take && irq_out) isr_nxt[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      isr_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wd;
      isr_q <= isr_nxt;
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter  int unsigned LINES = CTRL_LINES,
  parameter  int unsigned CASC  = CASC_INPUT,
  localparam int unsigned IW    = $clog2(LINES),
  localparam int unsigned NREQ  = 2 * LINES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] irq_req,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            cpu_ack,
  output logic            cpu_int,
  output logic [7:0]      ack_vector
);
  logic [NREQ-1:0]  req_s;
  logic [LINES-1:0] m_req, s_req;
  logic [LINES-1:0] m_mask_q, s_mask_q, m_isr_q, s_isr_q;
  logic             m_irq, s_irq, m_svc_any, s_svc_any;
  logic [IW-1:0]    m_pick, s_pick, m_svc_idx, s_svc_idx;
  logic             m_mask_we, s_mask_we, m_eoi, s_eoi, s_take;

  pirq_sync #(.W(NREQ)) u_sync (
    .clk(clk), .rst(rst), .d(irq_req), .q(req_s)
  );

  assign s_req = req_s[NREQ-1:LINES];

  // Master input CASC carries the slave's request; the raw line there is unused.
  for (genvar g = 0; g < LINES; g++) begin : g_mreq
    if (g == CASC) begin : g_casc
      assign m_req[g] = s_irq;
    end else begin : g_line
      assign m_req[g] = req_s[g];
    end
  end

  assign m_mask_we = reg_wr && (reg_addr == M_MASK_ADDR);
  assign s_mask_we = reg_wr && (reg_addr == S_MASK_ADDR);
  assign m_eoi     = reg_wr && (reg_addr == M_CTRL_ADDR) && reg_wdata[EOI_BIT];
  assign s_eoi     = reg_wr && (reg_addr == S_CTRL_ADDR) && reg_wdata[EOI_BIT];
  assign s_take    = cpu_ack && m_irq && (m_pick == IW'(CASC));

  pirq_unit #(.LINES(LINES)) u_master (
    .clk(clk), .rst(rst), .req(m_req), .mask_we(m_mask_we),
    .mask_wd(reg_wdata[LINES-1:0]), .eoi(m_eoi), .take(cpu_ack),
    .irq_out(m_irq), .pick(m_pick), .mask_q(m_mask_q), .isr_q(m_isr_q),
    .svc_any(m_svc_any), .svc_idx(m_svc_idx)
  );

  pirq_unit #(.LINES(LINES)) u_slave (
    .clk(clk), .rst(rst), .req(s_req), .mask_we(s_mask_we),
    .mask_wd(reg_wdata[LINES-1:0]), .eoi(s_eoi), .take(s_take),
    .irq_out(s_irq), .pick(s_pick), .mask_q(s_mask_q), .isr_q(s_isr_q),
    .svc_any(s_svc_any), .svc_idx(s_svc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_int    <= 1'b0;
      ack_vector <= '0;
    end else begin
      cpu_int <= m_irq;
      if (cpu_ack) begin
        if (!m_irq)     ack_vector <= M_VEC_BASE + 8'(LINES - 1);
        else if (s_take) ack_vector <= S_VEC_BASE + 8'(s_pick);
        else            ack_vector <= M_VEC_BASE + 8'(m_pick);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        M_CTRL_ADDR: reg_rdata <= svc_code(m_svc_any, 8'(m_svc_idx), 8'd0);
        S_CTRL_ADDR: reg_rdata <= svc_code(s_svc_any, 8'(s_svc_idx), 8'(LINES));
        M_MASK_ADDR: reg_rdata <= 8'(m_mask_q);
        S_MASK_ADDR: reg_rdata <= 8'(s_mask_q);
        default:     reg_rdata <= NONE_CODE;
      endcase
    end
  end
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk #(
  parameter int unsigned LINES = 8,
  parameter int unsigned CASC  = 2,
  parameter logic [7:0]  MBASE = 8'h08,
  parameter logic [7:0]  SBASE = 8'h70
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_ack,
  input logic             cpu_int,
  input logic [7:0]       ack_vector,
  input logic [LINES-1:0] m_mask,
  input logic [LINES-1:0] m_isr,
  input logic [LINES-1:0] s_isr
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cpu_int && m_mask == '1 && m_isr == '0 && s_isr == '0));

  assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(m_mask) == '1) |-> !cpu_int);

  assert_masked_not_serviced_R2: assert property (@(posedge clk) disable iff (rst)
    ((m_isr & ~$past(m_isr) & $past(m_mask)) == '0));

  assert_service_needs_ack_R9: assert property (@(posedge clk) disable iff (rst)
    ((m_isr & ~$past(m_isr)) != '0) |-> $past(cpu_ack));

  assert_slave_via_master_R7: assert property (@(posedge clk) disable iff (rst)
    ((s_isr & ~$past(s_isr)) != '0) |-> (m_isr[CASC] && !$past(m_isr[CASC])));

  assert_vector_window_R4: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_ack) |-> ((ack_vector >= MBASE && ack_vector < MBASE + 8'(LINES)) ||
                        (ack_vector >= SBASE && ack_vector < SBASE + 8'(LINES))));
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(
  .LINES(LINES), .CASC(CASC),
  .MBASE(casc_irq_pkg::M_VEC_BASE), .SBASE(casc_irq_pkg::S_VEC_BASE)
) chk_i (
  .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .cpu_int(cpu_int),
  .ack_vector(ack_vector), .m_mask(m_mask_q), .m_isr(m_isr_q), .s_isr(s_isr_q)
);

// File: tb/casc_irq_ctrl_tb_top.sv
module casc_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_req = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, cpu_ack = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata, ack_vector;
  logic        cpu_int;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  casc_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ack(cpu_ack), .cpu_int(cpu_int), .ack_vector(ack_vector)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0; v = ack_vector;
  endtask

  task automatic eoi_m(); wr(8'h20, 8'h20); endtask
  task automatic eoi_s(); wr(8'hA0, 8'h20); endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
    rd(8'h21, d); check("R1 master mask", d, 8'hFF);
    rd(8'hA1, d); check("R1 slave mask", d, 8'hFF);
    rd(8'h20, d); check("R1 master svc", d, 8'hFF);
    rd(8'hA0, d); check("R1 slave svc", d, 8'hFF);
  endtask

  task automatic t_masked();
    irq_req = 16'h0010; settle();
    check("R2 masked line quiet", {7'd0, cpu_int}, 8'h00);
    irq_req = '0; settle();
  endtask

  task automatic t_latency();
    @(negedge clk); irq_req = 16'h0040;
    @(negedge clk); check("R10 edge1", {7'd0, cpu_int}, 8'h00);
    @(negedge clk); check("R10 edge2", {7'd0, cpu_int}, 8'h00);
    @(negedge clk); check("R10 edge3", {7'd0, cpu_int}, 8'h01);
    irq_req = '0; settle();
    check("R10 withdrawn", {7'd0, cpu_int}, 8'h00);
  endtask

  task automatic t_single_and_block();
    logic [7:0] v, d;
    irq_req = 16'h0010; settle();
    check("R4 int line4", {7'd0, cpu_int}, 8'h01);
    ack(v); check("R4 vector line4", v, 8'h0C);
    rd(8'h20, d); check("R6 svc line4", d, 8'h04);
    settle(); check("R5 equal blocked", {7'd0, cpu_int}, 8'h00);
    eoi_m(); settle();
    check("R5 after eoi", {7'd0, cpu_int}, 8'h01);
    ack(v); irq_req = '0; eoi_m(); settle();
    rd(8'h20, d); check("R5 eoi cleared", d, 8'hFF);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    irq_req = 16'h0048; settle();
    ack(v); check("R3 line3 over line6", v, 8'h0B);
    irq_req = '0; eoi_m(); settle();
    irq_req = 16'h0001; settle();
    ack(v); check("R4 line0 vector", v, 8'h08);
    irq_req = '0; eoi_m(); settle();
  endtask

  task automatic t_cascade();
    logic [7:0] v, d;
    irq_req = 16'h0208; settle();
    ack(v); check("R3 slave group over line3", v, 8'h71);
    rd(8'h20, d); check("R6 master shows 2", d, 8'h02);
    rd(8'hA0, d); check("R6 slave shows 9", d, 8'h09);
    settle(); check("R7 line3 blocked", {7'd0, cpu_int}, 8'h00);
    eoi_s(); settle();
    check("R7 slave eoi alone", {7'd0, cpu_int}, 8'h00);
    eoi_m(); settle();
    check("R7 both eoi", {7'd0, cpu_int}, 8'h01);
    ack(v); check("R7 line9 again", v, 8'h71);
    irq_req = 16'h0008; eoi_s(); eoi_m(); settle();
    ack(v); check("R3 line3 after cascade", v, 8'h0B);
    irq_req = '0; eoi_m(); settle();
    irq_req = 16'h8000; settle();
    ack(v); check("R4 line15 vector", v, 8'h77);
    irq_req = '0; eoi_s(); eoi_m(); settle();
    irq_req = 16'h9000; settle();
    ack(v); check("R3 line12 over line15", v, 8'h74);
    irq_req = '0; eoi_s(); eoi_m(); settle();
  endtask

  task automatic t_preempt();
    logic [7:0] v, d;
    irq_req = 16'h0020; settle(); ack(v);
    check("R8 line5 first", v, 8'h0D);
    irq_req = 16'h0022; settle();
    check("R8 higher raises int", {7'd0, cpu_int}, 8'h01);
    ack(v); check("R8 line1 vector", v, 8'h09);
    rd(8'h20, d); check("R8 svc nested", d, 8'h01);
    eoi_m(); rd(8'h20, d); check("R5 back to line5", d, 8'h05);
    irq_req = '0; eoi_m(); rd(8'h20, d); check("R5 all clear", d, 8'hFF);
  endtask

  task automatic t_slave_mask();
    logic [7:0] v;
    wr(8'hA1, 8'h02); irq_req = 16'h0200; settle();
    check("R2 slave bit masks line9", {7'd0, cpu_int}, 8'h00);
    wr(8'hA1, 8'h00); wr(8'h21, 8'h04); settle();
    check("R2 master bit2 masks slave", {7'd0, cpu_int}, 8'h00);
    irq_req = '0; wr(8'h21, 8'h00); settle();
    ack(v); check("R9 spurious vector", v, 8'h0F);
    settle(); check("R9 no service", {7'd0, cpu_int}, 8'h00);
    irq_req = 16'h0080; settle();
    ack(v); check("R9 state intact line7", v, 8'h0F);
    irq_req = '0; eoi_m(); settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked();
    wr(8'h21, 8'h00);
    wr(8'hA1, 8'h00);
    t_latency();
    t_single_and_block();
    t_priority();
    t_cascade();
    t_preempt();
    t_slave_mask();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule